// File: doc/BRIEF.md
# Load-Use Stall Controller

This block lives in the decode stage of a five-stage in-order pipeline. It watches the instruction that has just entered the execute stage. If that instruction reads data memory and its target register is a source of the instruction now being decoded, the loaded value would arrive too late. The block then freezes the program counter and the fetch/decode register for one cycle. In the same cycle it replaces the control word entering the execute stage with all zeros, so one harmless bubble moves down the pipe. One cycle later the load has moved past the execute stage. The hazard clears by itself, and the held instruction moves on, with its operand available from the later stages.

The project wraps the detector in a small shell so that stall timing is visible at the ports. The shell holds a program counter, a fetch/decode register fed from an instruction port, and an execute-stage register that holds a decoded control word and the three register fields. It has no forwarding and no branch redirection.

Top module: `ld_stall_pipe`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 0, `ifid_instr` becomes 0, and `ex_ctrl` becomes 0. `stall` is then low.
- R2: `stall` is high when the execute-stage word has its memory-read bit set (`ex_ctrl[3]`), `ex_rt` is nonzero, and `ex_rt` equals the decode instruction's first source field, bits [25:21].
- R3: `stall` is high when the execute-stage word has its memory-read bit set, `ex_rt` is nonzero, and `ex_rt` equals the decode instruction's second source field, bits [20:16].
- R4: A memory-read instruction whose target field is register 0 never raises `stall`.
- R5: When the execute-stage memory-read bit is clear, `stall` is low, even for an instruction with the memory-write bit set.
- R6: At an edge where `stall` is high, `pc` keeps its value.
- R7: At an edge where `stall` is high, `ifid_instr` keeps its value and the word on `fetch_instr` is ignored.
- R8: At an edge where `stall` is high, `ex_ctrl` becomes all zeros (one bubble).
- R9: A stall lasts exactly one cycle. At the next edge, `pc` advances by 4 and the held instruction enters the execute stage with its decoded control word and its rs, rt and rd fields (bits [25:21], [20:16], [15:11]).
- R10: With no stall, every edge adds 4 to `pc`, loads `fetch_instr` into `ifid_instr`, and loads the execute stage from the decode instruction. Its opcode, bits [31:26], is decoded into `ex_ctrl` = {reg_dst, alu_op[1:0], alu_src, branch, mem_rd, mem_wr, reg_wr, mem_to_reg}. The codes are: 0x00 → 9'b1_10_0_0_0_0_1_0; 0x23 (load) → 9'b0_00_1_0_1_0_1_1; 0x2b (store) → 9'b0_00_1_0_0_1_0_0; 0x04 (branch) → 9'b0_01_0_1_0_0_0_0; any other opcode → 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr | input | 32 | Instruction word fetched at `pc` |
| pc | output | PC_W | Program counter |
| ifid_instr | output | 32 | Instruction held in the fetch/decode register |
| ex_ctrl | output | 9 | Control word held in the execute stage |
| ex_rs | output | 5 | First source field in the execute stage |
| ex_rt | output | 5 | Second source / load target field in the execute stage |
| ex_rd | output | 5 | Destination field in the execute stage |
| stall | output | 1 | Load-use hazard detected this cycle |

## Verification
The bench sweeps pairs of instructions. The first instruction is a load, an ALU operation or a store, with its target field taken over registers 0 to 7. The second instruction's two source fields each range over 0 to 7. The sweep separates a match on the first source from a match on the second, both from no match, and a real load from a non-load with the same fields. Register 0 as a load target shows that the zero register is excluded. For every pair, the bench follows the pipe for two edges after the pair meets. It confirms the frozen counter and the held fetch/decode word, and it confirms the zero control word in the bubble cycle. After that it confirms that the counter advances again and that the delayed instruction reaches the execute stage with its own control word and fields.

// File: rtl/ld_pkg.sv
package ld_pkg;
  localparam int INSTR_W = 32;
  localparam int RA_W    = 5;
  localparam int OP_W    = 6;

  localparam int OP_LSB  = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;

  localparam logic [OP_W-1:0] OPC_ALU    = 6'h00;
  localparam logic [OP_W-1:0] OPC_LOAD   = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE  = 6'h2b;
  localparam logic [OP_W-1:0] OPC_BRANCH = 6'h04;

  typedef struct packed {
    logic       reg_dst;
    logic [1:0] alu_op;
    logic       alu_src;
    logic       branch;
    logic       mem_rd;
    logic       mem_wr;
    logic       reg_wr;
    logic       mem_to_reg;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ld_ctrl_decode.sv
module ld_ctrl_decode
  import ld_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OPC_ALU: begin
        ctrl.reg_dst = 1'b1;
        ctrl.alu_op  = 2'b10;
        ctrl.reg_wr  = 1'b1;
      end
      OPC_LOAD: begin
        ctrl.alu_src    = 1'b1;
        ctrl.mem_rd     = 1'b1;
        ctrl.reg_wr     = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OPC_STORE: begin
        ctrl.alu_src = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OPC_BRANCH: begin
        ctrl.alu_op = 2'b01;
        ctrl.branch = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/ld_hazard_unit.sv
module ld_hazard_unit #(
  parameter int RA_W = 5
) (
  input  logic            ex_mem_rd,
  input  logic [RA_W-1:0] ex_rt,
  input  logic [RA_W-1:0] id_rs,
  input  logic [RA_W-1:0] id_rt,
  output logic            stall
);
  logic tgt_live;
  logic hit_rs;
  logic hit_rt;

  always_comb begin
    tgt_live = ex_mem_rd && (ex_rt != '0);
    hit_rs   = (ex_rt == id_rs);
    hit_rt   = (ex_rt == id_rt);
    stall    = tgt_live && (hit_rs || hit_rt);
  end
endmodule

// File: rtl/ld_bubble_mux.sv
module ld_bubble_mux #(
  parameter int W = 9
) (
  input  logic         kill,
  input  logic [W-1:0] ctrl_in,
  output logic [W-1:0] ctrl_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign ctrl_out[i] = ctrl_in[i] & ~kill;
  end
endmodule

// File: rtl/ld_stall_pipe.sv
module ld_stall_pipe
  import ld_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [INSTR_W-1:0]  fetch_instr,
  output logic [PC_W-1:0]     pc,
  output logic [INSTR_W-1:0]  ifid_instr,
  output logic [CTRL_W-1:0]   ex_ctrl,
  output logic [RA_W-1:0]     ex_rs,
  output logic [RA_W-1:0]     ex_rt,
  output logic [RA_W-1:0]     ex_rd,
  output logic                stall
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_W / 8);

  logic [OP_W-1:0] id_op;
  logic [RA_W-1:0] id_rs;
  logic [RA_W-1:0] id_rt;
  logic [RA_W-1:0] id_rd;
  ctrl_t           id_ctrl;
  logic [CTRL_W-1:0] id_ctrl_gated;
  logic            pc_we;
  logic            ifid_we;

  assign id_op = ifid_instr[OP_LSB +: OP_W];
  assign id_rs = ifid_instr[RS_LSB +: RA_W];
  assign id_rt = ifid_instr[RT_LSB +: RA_W];
  assign id_rd = ifid_instr[RD_LSB +: RA_W];

  ld_ctrl_decode u_dec (
    .opcode (id_op),
    .ctrl   (id_ctrl)
  );

  ld_hazard_unit #(.RA_W(RA_W)) u_haz (
    .ex_mem_rd (ex_ctrl[3]),
    .ex_rt     (ex_rt),
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .stall     (stall)
  );

  ld_bubble_mux #(.W(CTRL_W)) u_bub (
    .kill     (stall),
    .ctrl_in  (id_ctrl),
    .ctrl_out (id_ctrl_gated)
  );

  assign pc_we   = ~stall;
  assign ifid_we = ~stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
    end else if (pc_we) begin
      pc <= pc + PC_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ifid_instr <= '0;
    end else if (ifid_we) begin
      ifid_instr <= fetch_instr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_ctrl <= '0;
      ex_rs   <= '0;
      ex_rt   <= '0;
      ex_rd   <= '0;
    end else begin
      ex_ctrl <= id_ctrl_gated;
      ex_rs   <= id_rs;
      ex_rt   <= id_rt;
      ex_rd   <= id_rd;
    end
  end
endmodule

// File: rtl/ld_stall_pipe_chk.sv
module ld_stall_pipe_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] pc,
  input logic [31:0]     ifid_instr,
  input logic [8:0]      ex_ctrl,
  input logic [4:0]      ex_rt,
  input logic            stall
);
  p_zero_target_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_ctrl[3] && ex_rt == 5'd0) |-> !stall);

  p_no_load_r5: assert property (@(posedge clk) disable iff (rst)
    !ex_ctrl[3] |-> !stall);

  p_pc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    stall |=> pc == $past(pc));

  p_ifid_hold_r7: assert property (@(posedge clk) disable iff (rst)
    stall |=> ifid_instr == $past(ifid_instr));

  p_bubble_r8: assert property (@(posedge clk) disable iff (rst)
    stall |=> ex_ctrl == 9'd0);

  p_single_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    !stall |=> pc == $past(pc) + PC_W'(4));
endmodule

bind ld_stall_pipe ld_stall_pipe_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pc         (pc),
  .ifid_instr (ifid_instr),
  .ex_ctrl    (ex_ctrl),
  .ex_rt      (ex_rt),
  .stall      (stall)
);

// File: tb/tb_ld_stall_pipe.sv
module tb_ld_stall_pipe;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_instr = '0;
  logic [31:0] pc;
  logic [31:0] ifid_instr;
  logic [8:0]  ex_ctrl;
  logic [4:0]  ex_rs, ex_rt, ex_rd;
  logic        stall;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ld_stall_pipe dut (
    .clk(clk), .rst(rst), .fetch_instr(fetch_instr), .pc(pc),
    .ifid_instr(ifid_instr), .ex_ctrl(ex_ctrl), .ex_rs(ex_rs),
    .ex_rt(ex_rt), .ex_rd(ex_rd), .stall(stall)
  );

  function automatic logic [8:0] exp_ctrl(input logic [5:0] op);
    case (op)
      6'h00:   return 9'b1_10_0_0_0_0_1_0;
      6'h23:   return 9'b0_00_1_0_1_0_1_1;
      6'h2b:   return 9'b0_00_1_0_0_1_0_0;
      6'h04:   return 9'b0_01_0_1_0_0_0_0;
      default: return 9'b0;
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [4:0] rd);
    return {op, rs, rt, rd, 11'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs instruction a then b through the shell and follows the pipe.
  task automatic run_pair(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] c;
    logic        exp_st;
    logic [4:0]  a_rt, b_rs, b_rt;
    string       tag;
    c    = mk(6'h3f, 5'd0, 5'd0, 5'd0);
    a_rt = a[20:16];
    b_rs = b[25:21];
    b_rt = b[20:16];
    exp_st = (a[31:26] == 6'h23) && (a_rt != 5'd0) && (a_rt == b_rs || a_rt == b_rt);
    if (a[31:26] != 6'h23)      tag = "R5";
    else if (a_rt == 5'd0)      tag = "R4";
    else if (a_rt == b_rs)      tag = "R2";
    else if (a_rt == b_rt)      tag = "R3";
    else                        tag = "R2/R3 no-match";

    rst = 1'b1;
    fetch_instr = a;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);               // a now in IF/ID
    fetch_instr = b;
    @(negedge clk);               // a in ID/EX, b in IF/ID
    chk({tag, " stall"}, {31'd0, stall}, {31'd0, exp_st});
    chk("R10 pc", pc, 32'd8);
    fetch_instr = c;
    @(negedge clk);
    if (exp_st) begin
      chk("R6 pc hold", pc, 32'd8);
      chk("R7 ifid hold", ifid_instr, b);
      chk("R8 bubble", {23'd0, ex_ctrl}, 32'd0);
      chk("R9 one cycle", {31'd0, stall}, 32'd0);
      @(negedge clk);
      chk("R9 pc resumes", pc, 32'd12);
      chk("R9 ctrl", {23'd0, ex_ctrl}, {23'd0, exp_ctrl(b[31:26])});
      chk("R9 fields", {17'd0, ex_rs, ex_rt, ex_rd}, {17'd0, b[25:21], b[20:16], b[15:11]});
    end else begin
      chk("R10 pc step", pc, 32'd12);
      chk("R10 ifid load", ifid_instr, c);
      chk("R10 ctrl", {23'd0, ex_ctrl}, {23'd0, exp_ctrl(b[31:26])});
      chk("R10 fields", {17'd0, ex_rs, ex_rt, ex_rd}, {17'd0, b[25:21], b[20:16], b[15:11]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] ops[3];
    ops[0] = 6'h23; ops[1] = 6'h00; ops[2] = 6'h2b;
    fetch_instr = 32'hffff_ffff;
    @(negedge clk);
    @(negedge clk);
    chk("R1 pc", pc, 32'd0);
    chk("R1 ifid", ifid_instr, 32'd0);
    chk("R1 ctrl", {23'd0, ex_ctrl}, 32'd0);
    chk("R1 stall", {31'd0, stall}, 32'd0);

    // load into r2, then an ALU op reading r2 and r5
    run_pair(mk(6'h23, 5'd1, 5'd2, 5'd0), mk(6'h00, 5'd2, 5'd5, 5'd4));
    // branch decode and an unknown opcode in the second slot
    run_pair(mk(6'h23, 5'd1, 5'd3, 5'd0), mk(6'h04, 5'd6, 5'd7, 5'd1));
    run_pair(mk(6'h23, 5'd1, 5'd3, 5'd0), mk(6'h11, 5'd3, 5'd7, 5'd1));

    for (int k = 0; k < 3; k++)
      for (int art = 0; art < 8; art++)
        for (int brs = 0; brs < 8; brs++)
          for (int brt = 0; brt < 8; brt++)
            run_pair(mk(ops[k], 5'd1, 5'(art), 5'd9),
                     mk(6'h00, 5'(brs), 5'(brt), 5'(art + 10)));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule